// File: doc/BRIEF.md
# Timer interrupt flag controller

This block keeps the status flags of an eight-channel capture/compare timer and drives a single interrupt request from them. The timer datapath sends one-cycle event pulses: one per channel (a capture or a compare match), one for main counter overflow, two for pulse accumulator A (count overflow and input edge), one for pulse accumulator B overflow and one for the modulus down-counter reaching zero. Each pulse sets its flag on the next clock edge. A flag stays set until it is cleared.

Clearing follows one of two policies, selected by a mode bit in a control register. In the default policy, software writes a one to a flag's bit position to clear that flag. In the fast policy, writes to the flag registers do nothing. Instead, a flag is cleared as a side effect of the access that software makes anyway to the data register tied to that flag. The access type that clears depends on the register. For a channel it depends on whether the channel captures or compares.

The register bus has an address, a read strobe, a write strobe and write data. The block decodes the data-register addresses for their clearing side effect only. The data registers themselves live in the timer datapath.

Top module: `tmr_flag_ctrl`

## Requirements
- R1: After reset, every flag reads 0 and `irq_o` is 0. The clear policy is write-one-to-clear, every channel is in capture mode (mode bit 0) and every interrupt enable is 0.
- R2: With the fast-clear bit at 0, a write to address 0x00 clears each channel flag whose `bus_wdata_i` bit is 1. A write to address 0x01 does the same for the misc flags from `bus_wdata_i[4:0]`. The misc flag bits are: bit 0 counter overflow, bit 1 accumulator A overflow, bit 2 accumulator A edge, bit 3 accumulator B overflow, bit 4 modulus zero.
- R3: With the fast-clear bit at 0, reads and writes of the data-register addresses 0x10 to 0x1F leave every flag unchanged.
- R4: With the fast-clear bit (address 0x02, bit 0) at 1, writes to addresses 0x00 and 0x01 leave every flag unchanged.
- R5: With fast clear on, a read of channel i's data address (0x10+i) clears channel flag i when the channel's mode bit (address 0x03, bit i) is 0 (capture). A write to that address does not clear it.
- R6: With fast clear on and channel i's mode bit at 1 (compare), a write to address 0x10+i clears channel flag i. A read does not clear it.
- R7: With fast clear on, a read or a write of address 0x18 or 0x19 (main counter) clears misc bit 0.
- R8: With fast clear on, a read or a write of address 0x1A or 0x1B (accumulator A count) clears misc bits 1 and 2.
- R9: With fast clear on, a read or a write of address 0x1C or 0x1D (accumulator B count) clears misc bit 3.
- R10: With fast clear on, a read or a write of address 0x1E or 0x1F (modulus counter) clears misc bit 4.
- R11: When a set event and a clearing access reach the same flag in the same cycle, the flag is 1 afterwards.
- R12: `irq_o` is 1 exactly when some flag is 1 and its enable bit is also 1. Channel enables are at address 0x04, bits [7:0]. Misc enables are at address 0x05, bits [4:0], with the same bit layout as the misc flags.
- R13: An event pulse sets its flag on the next rising clock edge. No flag rises without its event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 8 | Register bus address |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| ev_ch_i | input | 8 | Per-channel capture/compare event pulses |
| ev_cnt_ovf_i | input | 1 | Main counter overflow event |
| ev_pa_ovf_i | input | 1 | Accumulator A overflow event |
| ev_pa_edge_i | input | 1 | Accumulator A input edge event |
| ev_pb_ovf_i | input | 1 | Accumulator B overflow event |
| ev_mod_zero_i | input | 1 | Modulus down-counter zero event |
| flags_ch_o | output | 8 | Channel flags |
| flags_misc_o | output | 5 | Misc flags (layout in R2) |
| irq_o | output | 1 | Combined interrupt request, active high |

## Verification
Suppose the policy bit or a channel's mode bit holds the wrong value. The wrong access then clears a flag, or the right access fails to clear it, and `flags_ch_o` or `flags_misc_o` shows this one edge after the bus strobe. A corrupted enable bit shows at once on `irq_o`, in the same cycle the flag or enable is registered. A lost set event shows at the flag output one edge after the pulse. The bench therefore checks every flag vector directly after each single-cycle access.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
    localparam int ADDR_W = 8;
    localparam int MISC_W = 5;

    // misc flag bit positions
    localparam int MB_CNT_OVF  = 0;
    localparam int MB_PA_OVF   = 1;
    localparam int MB_PA_EDGE  = 2;
    localparam int MB_PB_OVF   = 3;
    localparam int MB_MOD_ZERO = 4;

    // register bus addresses
    localparam logic [ADDR_W-1:0] A_FLAG_CH   = 8'h00;
    localparam logic [ADDR_W-1:0] A_FLAG_MISC = 8'h01;
    localparam logic [ADDR_W-1:0] A_CTRL      = 8'h02;
    localparam logic [ADDR_W-1:0] A_CH_MODE   = 8'h03;
    localparam logic [ADDR_W-1:0] A_EN_CH     = 8'h04;
    localparam logic [ADDR_W-1:0] A_EN_MISC   = 8'h05;
    localparam logic [ADDR_W-1:0] A_CH_DATA   = 8'h10;
    localparam logic [ADDR_W-1:0] A_CNT       = 8'h18;
    localparam logic [ADDR_W-1:0] A_PA_CNT    = 8'h1A;
    localparam logic [ADDR_W-1:0] A_PB_CNT    = 8'h1C;
    localparam logic [ADDR_W-1:0] A_MOD_CNT   = 8'h1E;

    // two-byte counters: match ignoring the low address bit
    function automatic logic pair_hit(input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] base);
        return addr[ADDR_W-1:1] == base[ADDR_W-1:1];
    endfunction
endpackage

// File: rtl/tfc_cfg_regs.sv
module tfc_cfg_regs
    import tfc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic                 fast_o,
    output logic [NUM_CH-1:0]    ch_cmp_o,
    output logic [NUM_CH-1:0]    en_ch_o,
    output logic [MISC_W-1:0]    en_misc_o
);
    typedef struct packed {
        logic                fast;
        logic [NUM_CH-1:0]   cmp;
        logic [NUM_CH-1:0]   en_ch;
        logic [MISC_W-1:0]   en_misc;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            unique case (addr_i)
                A_CTRL:    cfg_d.fast    = wdata_i[0];
                A_CH_MODE: cfg_d.cmp     = wdata_i[NUM_CH-1:0];
                A_EN_CH:   cfg_d.en_ch   = wdata_i[NUM_CH-1:0];
                A_EN_MISC: cfg_d.en_misc = wdata_i[MISC_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign fast_o    = cfg_q.fast;
    assign ch_cmp_o  = cfg_q.cmp;
    assign en_ch_o   = cfg_q.en_ch;
    assign en_misc_o = cfg_q.en_misc;
endmodule

// File: rtl/tfc_clear_decode.sv
module tfc_clear_decode
    import tfc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               fast_i,
    input  logic [NUM_CH-1:0]  ch_cmp_i,
    output logic [NUM_CH-1:0]  clr_ch_o,
    output logic [MISC_W-1:0]  clr_misc_o
);
    logic               acc;
    logic [NUM_CH-1:0]  fast_ch;
    logic [MISC_W-1:0]  fast_misc;

    assign acc = rd_i | wr_i;

    // per channel: the access kind that clears follows the channel mode
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit        = (addr_i == A_CH_DATA + ADDR_W'(g));
        assign fast_ch[g] = hit & (ch_cmp_i[g] ? wr_i : rd_i);
    end

    always_comb begin
        fast_misc              = '0;
        fast_misc[MB_CNT_OVF]  = acc & pair_hit(addr_i, A_CNT);
        fast_misc[MB_PA_OVF]   = acc & pair_hit(addr_i, A_PA_CNT);
        fast_misc[MB_PA_EDGE]  = acc & pair_hit(addr_i, A_PA_CNT);
        fast_misc[MB_PB_OVF]   = acc & pair_hit(addr_i, A_PB_CNT);
        fast_misc[MB_MOD_ZERO] = acc & pair_hit(addr_i, A_MOD_CNT);
    end

    always_comb begin
        clr_ch_o   = '0;
        clr_misc_o = '0;
        if (fast_i) begin
            clr_ch_o   = fast_ch;
            clr_misc_o = fast_misc;
        end else if (wr_i) begin
            if (addr_i == A_FLAG_CH)   clr_ch_o   = wdata_i[NUM_CH-1:0];
            if (addr_i == A_FLAG_MISC) clr_misc_o = wdata_i[MISC_W-1:0];
        end
    end
endmodule

// File: rtl/tfc_flag_bank.sv
module tfc_flag_bank #(
    parameter int W = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [W-1:0]  set_i,
    input  logic [W-1:0]  clr_i,
    output logic [W-1:0]  flags_o
);
    typedef struct packed {
        logic [W-1:0] flags;
    } bank_t;

    bank_t bank_d, bank_q;

    // set has priority so that no event is dropped
    always_comb begin
        bank_d       = bank_q;
        bank_d.flags = (bank_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bank_q <= '0;
        else         bank_q <= bank_d;
    end

    assign flags_o = bank_q.flags;
endmodule

// File: rtl/tfc_irq_combine.sv
module tfc_irq_combine
    import tfc_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0]  flags_ch_i,
    input  logic [MISC_W-1:0]  flags_misc_i,
    input  logic [NUM_CH-1:0]  en_ch_i,
    input  logic [MISC_W-1:0]  en_misc_i,
    output logic               irq_o
);
    assign irq_o = (|(flags_ch_i & en_ch_i)) | (|(flags_misc_i & en_misc_i));
endmodule

// File: rtl/tmr_flag_ctrl.sv
module tmr_flag_ctrl
    import tfc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [7:0]          bus_addr_i,
    input  logic                bus_rd_i,
    input  logic                bus_wr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    input  logic [NUM_CH-1:0]   ev_ch_i,
    input  logic                ev_cnt_ovf_i,
    input  logic                ev_pa_ovf_i,
    input  logic                ev_pa_edge_i,
    input  logic                ev_pb_ovf_i,
    input  logic                ev_mod_zero_i,
    output logic [NUM_CH-1:0]   flags_ch_o,
    output logic [4:0]          flags_misc_o,
    output logic                irq_o
);
    logic                fast_mode;
    logic [NUM_CH-1:0]   ch_cmp, en_ch, clr_ch;
    logic [MISC_W-1:0]   en_misc, clr_misc, ev_misc;

    always_comb begin
        ev_misc              = '0;
        ev_misc[MB_CNT_OVF]  = ev_cnt_ovf_i;
        ev_misc[MB_PA_OVF]   = ev_pa_ovf_i;
        ev_misc[MB_PA_EDGE]  = ev_pa_edge_i;
        ev_misc[MB_PB_OVF]   = ev_pb_ovf_i;
        ev_misc[MB_MOD_ZERO] = ev_mod_zero_i;
    end

    tfc_cfg_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) cfg_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (bus_addr_i),
        .wr_i      (bus_wr_i),
        .wdata_i   (bus_wdata_i),
        .fast_o    (fast_mode),
        .ch_cmp_o  (ch_cmp),
        .en_ch_o   (en_ch),
        .en_misc_o (en_misc)
    );

    tfc_clear_decode #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dec_i (
        .addr_i     (bus_addr_i),
        .rd_i       (bus_rd_i),
        .wr_i       (bus_wr_i),
        .wdata_i    (bus_wdata_i),
        .fast_i     (fast_mode),
        .ch_cmp_i   (ch_cmp),
        .clr_ch_o   (clr_ch),
        .clr_misc_o (clr_misc)
    );

    tfc_flag_bank #(.W(NUM_CH)) ch_bank_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (ev_ch_i),
        .clr_i   (clr_ch),
        .flags_o (flags_ch_o)
    );

    tfc_flag_bank #(.W(MISC_W)) misc_bank_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (ev_misc),
        .clr_i   (clr_misc),
        .flags_o (flags_misc_o)
    );

    tfc_irq_combine #(.NUM_CH(NUM_CH)) irq_i (
        .flags_ch_i   (flags_ch_o),
        .flags_misc_i (flags_misc_o),
        .en_ch_i      (en_ch),
        .en_misc_i    (en_misc),
        .irq_o        (irq_o)
    );
endmodule

// File: rtl/tmr_flag_ctrl_chk.sv
module tmr_flag_ctrl_chk
    import tfc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 8
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [7:0]          addr_i,
    input logic                rd_i,
    input logic                wr_i,
    input logic [DATA_W-1:0]   wdata_i,
    input logic [NUM_CH-1:0]   ev_ch_i,
    input logic [MISC_W-1:0]   ev_misc_i,
    input logic                fast_i,
    input logic [NUM_CH-1:0]   flags_ch_i,
    input logic [MISC_W-1:0]   flags_misc_i,
    input logic                irq_i
);
    // R13 / R11: a channel event always leaves its flag set
    a_r13_ch_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_ch_i != '0) |=> ((flags_ch_i & $past(ev_ch_i)) == $past(ev_ch_i)));

    // R11: misc events win over any clearing access
    a_r11_misc_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_misc_i != '0) |=> ((flags_misc_i & $past(ev_misc_i)) == $past(ev_misc_i)));

    // R13: no channel flag rises without its event
    a_r13_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_ch_i == '0) |=> ((flags_ch_i & ~$past(flags_ch_i)) == '0));

    // R2: write-one-to-clear on the channel flag register
    a_r2_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fast_i && wr_i && addr_i == A_FLAG_CH && ev_ch_i == '0)
        |=> (flags_ch_i == ($past(flags_ch_i) & ~$past(wdata_i[NUM_CH-1:0]))));

    // R4: in fast mode, writes to the flag register clear nothing
    a_r4_fast_no_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fast_i && wr_i && addr_i == A_FLAG_CH)
        |=> ((flags_ch_i & $past(flags_ch_i)) == $past(flags_ch_i)));

    // R3: in normal mode, data-register accesses clear nothing
    a_r3_no_implicit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fast_i && (rd_i || wr_i) && addr_i[7:4] == 4'h1)
        |=> ((flags_misc_i & $past(flags_misc_i)) == $past(flags_misc_i)));

    // R12: no flag set means no request
    a_r12_quiet_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_ch_i == '0 && flags_misc_i == '0) |-> !irq_i);
endmodule

bind tmr_flag_ctrl tmr_flag_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (bus_addr_i),
    .rd_i         (bus_rd_i),
    .wr_i         (bus_wr_i),
    .wdata_i      (bus_wdata_i),
    .ev_ch_i      (ev_ch_i),
    .ev_misc_i    (ev_misc),
    .fast_i       (fast_mode),
    .flags_ch_i   (flags_ch_o),
    .flags_misc_i (flags_misc_o),
    .irq_i        (irq_o)
);

// File: tb/tmr_flag_ctrl_tb_top.sv
`timescale 1ns/100ps
module tmr_flag_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] ev_ch = '0;
    logic [4:0] ev_misc = '0;
    logic [7:0] flags_ch;
    logic [4:0] flags_misc;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_flag_ctrl dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .bus_addr_i    (addr),
        .bus_rd_i      (rd),
        .bus_wr_i      (wr),
        .bus_wdata_i   (wdata),
        .ev_ch_i       (ev_ch),
        .ev_cnt_ovf_i  (ev_misc[0]),
        .ev_pa_ovf_i   (ev_misc[1]),
        .ev_pa_edge_i  (ev_misc[2]),
        .ev_pb_ovf_i   (ev_misc[3]),
        .ev_mod_zero_i (ev_misc[4]),
        .flags_ch_o    (flags_ch),
        .flags_misc_o  (flags_misc),
        .irq_o         (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one bus/event cycle, driven at the falling edge
    task automatic cyc(input logic [7:0] a, input logic r, input logic w,
                       input logic [7:0] wd, input logic [7:0] ech, input logic [4:0] em);
        addr = a; rd = r; wr = w; wdata = wd; ev_ch = ech; ev_misc = em;
        @(negedge clk);
        addr = '0; rd = 1'b0; wr = 1'b0; wdata = '0; ev_ch = '0; ev_misc = '0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        cyc(a, 1'b0, 1'b1, d, 8'h00, 5'h00);
    endtask

    task automatic rd_reg(input logic [7:0] a);
        cyc(a, 1'b1, 1'b0, 8'h00, 8'h00, 5'h00);
    endtask

    task automatic fire(input logic [7:0] ech, input logic [4:0] em);
        cyc(8'h00, 1'b0, 1'b0, 8'h00, ech, em);
    endtask

    task automatic t_reset();
        chk("R1 ch flags", flags_ch, 0);
        chk("R1 misc flags", flags_misc, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_event_set();
        fire(8'h40, 5'h00);
        chk("R13 ch6 set", flags_ch, 'h40);
        fire(8'h00, 5'h04);
        chk("R13 misc edge set", flags_misc, 'h04);
        fire(8'h00, 5'h00);
        chk("R13 no spurious ch", flags_ch, 'h40);
        chk("R13 no spurious misc", flags_misc, 'h04);
    endtask

    task automatic t_w1c();
        fire(8'hFF, 5'h1F);
        wr_reg(8'h00, 8'h0F);
        chk("R2 ch w1c (R1 default policy)", flags_ch, 'hF0);
        wr_reg(8'h01, 8'h05);
        chk("R2 misc w1c", flags_misc, 'h1A);
        wr_reg(8'h00, 8'hFF);
        wr_reg(8'h01, 8'hFF);
        chk("R2 ch all clear", flags_ch, 0);
        chk("R2 misc all clear", flags_misc, 0);
    endtask

    task automatic t_normal_no_implicit();
        fire(8'hFF, 5'h1F);
        rd_reg(8'h13);
        wr_reg(8'h14, 8'h55);
        chk("R3 ch unchanged", flags_ch, 'hFF);
        rd_reg(8'h18);
        wr_reg(8'h1A, 8'h00);
        rd_reg(8'h1D);
        wr_reg(8'h1E, 8'h00);
        chk("R3 misc unchanged", flags_misc, 'h1F);
        wr_reg(8'h00, 8'hFF);
        wr_reg(8'h01, 8'hFF);
    endtask

    task automatic t_fast_no_w1c();
        wr_reg(8'h02, 8'h01);
        fire(8'hFF, 5'h1F);
        wr_reg(8'h00, 8'hFF);
        chk("R4 ch kept", flags_ch, 'hFF);
        wr_reg(8'h01, 8'hFF);
        chk("R4 misc kept", flags_misc, 'h1F);
    endtask

    task automatic t_fast_capture();
        rd_reg(8'h12);
        chk("R5 capture read clears (R1 mode capture)", flags_ch, 'hFB);
        wr_reg(8'h13, 8'hAA);
        chk("R5 capture write ignored", flags_ch, 'hFB);
    endtask

    task automatic t_fast_compare();
        wr_reg(8'h03, 8'h30);
        wr_reg(8'h14, 8'h12);
        chk("R6 compare write clears", flags_ch, 'hEB);
        rd_reg(8'h15);
        chk("R6 compare read ignored", flags_ch, 'hEB);
        wr_reg(8'h15, 8'h00);
        chk("R6 compare write clears ch5", flags_ch, 'hCB);
    endtask

    task automatic t_fast_misc();
        rd_reg(8'h19);
        chk("R7 counter access", flags_misc, 'h1E);
        wr_reg(8'h1A, 8'h00);
        chk("R8 acc A access", flags_misc, 'h18);
        rd_reg(8'h1D);
        chk("R9 acc B access", flags_misc, 'h10);
        wr_reg(8'h1E, 8'h00);
        chk("R10 modulus access", flags_misc, 'h00);
    endtask

    task automatic t_set_wins();
        cyc(8'h12, 1'b1, 1'b0, 8'h00, 8'h04, 5'h00);
        chk("R11 ch set beats read clear", flags_ch, 'hCF);
        cyc(8'h18, 1'b1, 1'b0, 8'h00, 8'h00, 5'h01);
        chk("R11 misc set beats access", flags_misc, 'h01);
        wr_reg(8'h02, 8'h00);
        cyc(8'h00, 1'b0, 1'b1, 8'hFF, 8'h01, 5'h00);
        chk("R11 set beats w1c", flags_ch, 'h01);
        wr_reg(8'h00, 8'hFF);
        wr_reg(8'h01, 8'hFF);
    endtask

    task automatic t_irq();
        fire(8'h08, 5'h00);
        chk("R12 disabled no irq", irq, 0);
        wr_reg(8'h04, 8'h08);
        chk("R12 enabled irq", irq, 1);
        wr_reg(8'h04, 8'hF7);
        chk("R12 other enables", irq, 0);
        wr_reg(8'h04, 8'h00);
        fire(8'h00, 5'h10);
        chk("R12 misc disabled", irq, 0);
        wr_reg(8'h05, 8'h10);
        chk("R12 misc enabled", irq, 1);
        wr_reg(8'h01, 8'h10);
        chk("R12 cleared drops irq", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_event_set();
        t_w1c();
        t_normal_no_implicit();
        t_fast_no_w1c();
        t_fast_capture();
        t_fast_compare();
        t_fast_misc();
        t_set_wins();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule